// File: doc/BRIEF.md
# ATM Transmit Cell Serializer

This block drains ATM cells from a transmit word FIFO and presents them one octet per transfer to a cell-oriented physical-layer transmit port. Each stored cell occupies thirteen 32-bit words: a 4-byte header followed by a 48-byte payload. While it sends a cell, the block splits each word into octets, most significant octet first. After the header it inserts a zero octet that reserves the header-check position. This octet takes nothing from the FIFO, so 52 stored bytes go out as a 53-byte cell.

The FIFO is a show-ahead FIFO: its head word is always present on `fifo_rdata`, and a one-cycle `fifo_rd` pulse pops that word. The FIFO side raises `cell_avail` whenever at least one whole cell is stored. The block starts a cell only at a cell boundary, and only while `cell_avail` is high. Once a cell has started, it is sent to the end without stalling on the FIFO. On the output side, a valid/ready handshake moves one octet per accepted cycle, and a start-of-cell marker travels with the first octet. When the port is ready but no cell is stored at a boundary, the block drops valid and latches a sticky underflow flag. That flag stays set until software pulses a clear.

Top module: `atm_tx_cell_serializer`

## Requirements
- R1: Each FIFO word is sent as four octets, bits 31:24 first, then 23:16, then 15:8, then 7:0.
- R2: `fifo_rd` pulses for exactly one cycle in the cycle where the first octet of a word is loaded into the output register. This gives exactly 13 pulses per cell, and none for the header-check octet.
- R3: The octet at cell offset 4 (the fifth octet, counting from offset 0) is always 8'h00 and follows the fourth header octet.
- R4: Every cell is exactly 53 octets long. A cell starts only when `cell_avail` is high at a cell boundary, so a FIFO holding fewer than 13 words produces no output.
- R5: `phy_soc` is high together with `phy_valid` on the first octet of every cell, and low on every other octet.
- R6: At a cell boundary with no cell available, `phy_valid` is low.
- R7: While `phy_valid` is high and `phy_ready` is low, `phy_data`, `phy_soc` and `phy_valid` hold their values and no FIFO word is read.
- R8: `unfl_flag` is set one cycle after a cycle in which the output register is free, the block is at a cell boundary, `phy_ready` is high and `cell_avail` is low. Once set, it stays set until `unfl_clr` is high, and a set in the same cycle as a clear wins.
- R9: Synchronous reset `rst` returns the block to a cell boundary with `phy_valid`, `phy_soc`, `fifo_rd` and `unfl_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_rdata | input | 32 | Head word of the show-ahead transmit FIFO |
| cell_avail | input | 1 | At least one complete cell (13 words) is stored |
| fifo_rd | output | 1 | Pop the head word of the FIFO |
| phy_data | output | 8 | Octet to the physical transmit port |
| phy_valid | output | 1 | `phy_data` holds an octet of a cell |
| phy_soc | output | 1 | Current octet is the first of a cell |
| phy_ready | input | 1 | Physical port accepts the current octet |
| unfl_flag | output | 1 | Sticky underflow status |
| unfl_clr | input | 1 | Clears `unfl_flag` |

## Verification
A wrong byte-position count shows up within one cell. Depending on the error, the zero octet lands at an offset other than 4, `fifo_rd` pulses at the wrong offset, or `phy_soc` no longer arrives every 53 accepted octets. A wrong lane select or word register corrupts `phy_data` on the very next accepted octet. A stall that loses state shows as a changed octet or a missing octet while `phy_ready` is low. A flaw in the flag logic shows one cycle after a starved or cleared cycle. A per-cycle reference model catches each of these on the first clock where it shows at the ports.

// File: rtl/atm_txs_pkg.sv
package atm_txs_pkg;

  localparam int unsigned OCTET_W   = 8;
  localparam int unsigned HDR_LEN   = 4;
  localparam int unsigned PAY_LEN   = 48;
  localparam int unsigned FIFO_W    = 32;

  // True when the cell offset is the reserved header-check slot.
  function automatic logic pos_is_hec(input int pos, input int hdr);
    return (pos == hdr);
  endfunction

  // Octet lane inside the FIFO word that feeds a cell offset.
  // Offsets past the reserved slot map back by one stored byte.
  function automatic int pos_lane(input int pos, input int hdr, input int wbytes);
    int stored;
    stored = (pos > hdr) ? pos - 1 : pos;
    return stored % wbytes;
  endfunction

endpackage

// File: rtl/atm_txs_seq.sv
module atm_txs_seq #(
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned POS_W      = $clog2(CELL_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [POS_W-1:0] pos,
  output logic             at_boundary,
  output logic             at_last
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_BYTES - 1);

  assign at_boundary = (pos == '0);
  assign at_last     = (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
    end else if (step) begin
      pos <= at_last ? '0 : pos + POS_W'(1);
    end
  end

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (rst)
    pos <= LAST_POS); // R4

  AST_WRAP_TO_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (step && at_last) |=> at_boundary); // R4

endmodule

// File: rtl/atm_txs_unpack.sv
module atm_txs_unpack
  import atm_txs_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned HDR_BYTES = 4,
  parameter int unsigned POS_W     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [POS_W-1:0]  pos,
  input  logic [WORD_W-1:0] word_in,
  output logic [BYTE_W-1:0] byte_out,
  output logic              rd_need,
  output logic              hec_slot
);

  localparam int unsigned WORD_BYTES = WORD_W / BYTE_W;
  localparam int unsigned LANE_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;

  logic [WORD_W-1:0] word_q;
  logic [LANE_W-1:0] lane_idx;
  logic [BYTE_W-1:0] lane_byte [WORD_BYTES];

  assign hec_slot = pos_is_hec(int'(pos), int'(HDR_BYTES));
  assign lane_idx = LANE_W'(pos_lane(int'(pos), int'(HDR_BYTES), int'(WORD_BYTES)));
  assign rd_need  = !hec_slot && (lane_idx == '0);

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign lane_byte[g] = word_q[WORD_W-1-g*BYTE_W -: BYTE_W];
  end

  always_comb begin
    if (hec_slot)            byte_out = '0;
    else if (lane_idx == '0) byte_out = word_in[WORD_W-1 -: BYTE_W];
    else                     byte_out = lane_byte[lane_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (load && rd_need) begin
      word_q <= word_in;
    end
  end

  AST_HEC_NO_LANE_READ: assert property (@(posedge clk) disable iff (rst)
    hec_slot |-> !rd_need); // R2

endmodule

// File: rtl/atm_txs_unfl.sv
module atm_txs_unfl (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_UNFL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag); // R8

  AST_UNFL_SET: assert property (@(posedge clk) disable iff (rst)
    set |=> flag); // R8

endmodule

// File: rtl/atm_tx_cell_serializer.sv
module atm_tx_cell_serializer
  import atm_txs_pkg::*;
#(
  parameter int unsigned WORD_W    = FIFO_W,
  parameter int unsigned BYTE_W    = OCTET_W,
  parameter int unsigned HDR_BYTES = HDR_LEN,
  parameter int unsigned PAY_BYTES = PAY_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              cell_avail,
  output logic              fifo_rd,
  output logic [BYTE_W-1:0] phy_data,
  output logic              phy_valid,
  output logic              phy_soc,
  input  logic              phy_ready,
  output logic              unfl_flag,
  input  logic              unfl_clr
);

  localparam int unsigned CELL_BYTES = HDR_BYTES + 1 + PAY_BYTES;
  localparam int unsigned POS_W      = $clog2(CELL_BYTES);

  logic [POS_W-1:0]  pos;
  logic              at_boundary;
  logic              at_last;
  logic [BYTE_W-1:0] next_byte;
  logic              rd_need;
  logic              hec_slot;

  // Named internal events
  logic out_free;     // output register empty or being taken
  logic step;         // an octet is loaded this cycle
  logic cell_start;   // first octet of a cell is loaded
  logic hec_load;     // header-check placeholder is loaded
  logic starve;       // boundary reached with nothing to send

  assign out_free   = !phy_valid || phy_ready;
  assign step       = out_free && (!at_boundary || cell_avail);
  assign cell_start = out_free && at_boundary && cell_avail;
  assign hec_load   = step && hec_slot;
  assign starve     = out_free && at_boundary && !cell_avail && phy_ready;
  assign fifo_rd    = step && rd_need;

  atm_txs_seq #(
    .CELL_BYTES(CELL_BYTES),
    .POS_W     (POS_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .pos        (pos),
    .at_boundary(at_boundary),
    .at_last    (at_last)
  );

  atm_txs_unpack #(
    .WORD_W   (WORD_W),
    .BYTE_W   (BYTE_W),
    .HDR_BYTES(HDR_BYTES),
    .POS_W    (POS_W)
  ) u_unpack (
    .clk     (clk),
    .rst     (rst),
    .load    (step),
    .pos     (pos),
    .word_in (fifo_rdata),
    .byte_out(next_byte),
    .rd_need (rd_need),
    .hec_slot(hec_slot)
  );

  atm_txs_unfl u_unfl (
    .clk (clk),
    .rst (rst),
    .set (starve),
    .clr (unfl_clr),
    .flag(unfl_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_valid <= 1'b0;
      phy_soc   <= 1'b0;
      phy_data  <= '0;
    end else if (out_free) begin
      phy_valid <= step;
      phy_soc   <= cell_start;
      phy_data  <= step ? next_byte : '0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (phy_valid && !phy_ready) |=> (phy_valid && $stable(phy_data) && $stable(phy_soc))); // R7

  AST_NO_READ_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    (phy_valid && !phy_ready) |-> !fifo_rd); // R7

  AST_SOC_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    phy_soc |-> phy_valid); // R5

  AST_HEC_ZERO: assert property (@(posedge clk) disable iff (rst)
    hec_load |=> (phy_valid && phy_data == '0)); // R3

  AST_LAST_THEN_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    (step && at_last) |=> !phy_soc); // R5

  AST_STARVE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    starve |=> !phy_valid); // R6

endmodule

// File: tb/tb_atm_tx_cell_serializer.sv
module tb_atm_tx_cell_serializer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fifo_rdata = '0;
  logic        cell_avail = 1'b0;
  logic        fifo_rd;
  logic [7:0]  phy_data;
  logic        phy_valid;
  logic        phy_soc;
  logic        phy_ready = 1'b0;
  logic        unfl_flag;
  logic        unfl_clr = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  atm_tx_cell_serializer dut (
    .clk(clk), .rst(rst), .fifo_rdata(fifo_rdata), .cell_avail(cell_avail),
    .fifo_rd(fifo_rd), .phy_data(phy_data), .phy_valid(phy_valid),
    .phy_soc(phy_soc), .phy_ready(phy_ready), .unfl_flag(unfl_flag),
    .unfl_clr(unfl_clr)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // Bench FIFO and reference model state
  logic [31:0] fifo [$];
  logic [9:0]  expq [$];   // {soc, pop, octet}
  logic        m_valid = 1'b0;
  logic        m_soc   = 1'b0;
  logic [7:0]  m_data  = '0;
  logic        m_unfl  = 1'b0;

  // Receive-side bookkeeping
  int          cells_rx = 0;
  int          bytes_rx = 0;
  int          cur_len  = 0;
  logic [7:0]  cap [8];
  int          capn = 0;
  int          cells_tx = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_cell(input bit fixed);
    for (int w = 0; w < 13; w++) begin
      if (fixed) fifo.push_back(32'h11223344 + 32'h01010101 * w);
      else       fifo.push_back($urandom);
    end
    cells_tx++;
  endtask

  // Expand the 13 head words into the 53 octets the port must see.
  task automatic expand_cell();
    logic [9:0] flat [$];
    for (int w = 0; w < 13; w++)
      for (int b = 0; b < 4; b++)
        flat.push_back({1'b0, (b == 0), fifo[w][31 - 8*b -: 8]});
    flat[0][9] = 1'b1;
    flat.insert(4, 10'h000);
    foreach (flat[i]) expq.push_back(flat[i]);
  endtask

  // One clock: compare, drive, model, edge.
  task automatic tick(input logic rdy, input logic clr);
    logic adv;
    logic e_rd;
    logic setf;
    logic rd_s;
    logic [9:0] e;
    chk("R6 valid", phy_valid, m_valid);
    if (m_valid) begin
      chk("R1 data", phy_data, m_data);
      chk("R5 soc", phy_soc, m_soc);
    end
    chk("R8 unfl", unfl_flag, m_unfl);
    phy_ready  = rdy;
    unfl_clr   = clr;
    cell_avail = (fifo.size() >= 13);
    fifo_rdata = (fifo.size() > 0) ? fifo[0] : 32'h0;
    #1;
    if (phy_valid && phy_ready) begin
      if (phy_soc) begin
        if (cur_len != 0) chk("R4 cell length", cur_len, 53);
        cells_rx++;
        cur_len = 0;
      end
      if (cur_len == 4) chk("R3 hec octet", phy_data, 8'h00);
      if (capn < 8) begin cap[capn] = phy_data; capn++; end
      cur_len++;
      bytes_rx++;
    end
    adv  = !m_valid || rdy;
    e_rd = 1'b0;
    setf = 1'b0;
    if (adv) begin
      if (expq.size() == 0 && fifo.size() >= 13) expand_cell();
      if (expq.size() > 0) begin
        e       = expq.pop_front();
        m_valid = 1'b1;
        m_soc   = e[9];
        e_rd    = e[8];
        m_data  = e[7:0];
      end else begin
        m_valid = 1'b0;
        m_soc   = 1'b0;
        m_data  = '0;
        if (rdy) setf = 1'b1;
      end
    end
    if (setf)     m_unfl = 1'b1;
    else if (clr) m_unfl = 1'b0;
    chk("R2 fifo_rd", fifo_rd, e_rd);
    rd_s = fifo_rd;
    @(posedge clk);
    if (rd_s && fifo.size() > 0) void'(fifo.pop_front());
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // Reset state (R9)
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 valid", phy_valid, 1'b0);
    chk("R9 soc", phy_soc, 1'b0);
    chk("R9 fifo_rd", fifo_rd, 1'b0);
    chk("R9 unfl", unfl_flag, 1'b0);
    rst = 1'b0;

    // Two known cells back to back, port always ready
    push_cell(1'b1);
    push_cell(1'b1);
    repeat (130) tick(1'b1, 1'b0);
    chk("R1 octet0", cap[0], 8'h11);
    chk("R1 octet1", cap[1], 8'h22);
    chk("R1 octet2", cap[2], 8'h33);
    chk("R1 octet3", cap[3], 8'h44);
    chk("R3 octet4", cap[4], 8'h00);
    chk("R1 octet5", cap[5], 8'h12);
    chk("R8 set after starve", unfl_flag, 1'b1);

    // Clear while the port is not ready: no new set
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b0);
    chk("R8 cleared", unfl_flag, 1'b0);

    // Twelve words only: nothing may start
    for (int w = 0; w < 12; w++) fifo.push_back($urandom);
    repeat (10) tick(1'b1, 1'b0);
    chk("R4 partial cell idle", phy_valid, 1'b0);
    fifo.push_back($urandom);
    cells_tx++;

    // Random back-pressure with cells arriving over time
    for (int c = 0; c < 2400; c++) begin
      if (c % 150 == 0 && c < 1200) push_cell(1'b0);
      tick(($urandom % 3) != 0, ($urandom % 40) == 0);
    end
    repeat (300) tick(1'b1, 1'b0);
    chk("R4 cell count", cells_rx, cells_tx);
    chk("R4 octet total", bytes_rx, 53 * cells_tx);
    chk("R4 last cell length", cur_len, 53);
    chk("R2 fifo drained", fifo.size(), 0);

    // Set and clear together: set wins
    tick(1'b1, 1'b1);
    chk("R8 set beats clear", unfl_flag, 1'b1);
    tick(1'b0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule